// File: doc/BRIEF.md
# Splittable Performance Counter Bank

The block holds four physical 32-bit event counters that software can reconfigure at run time. Each physical counter works either as one 32-bit counter or as two independent 16-bit halves, so the bank offers up to eight logical counters.

Each logical counter has its own control word. The control word picks one of 64 event inputs, can invert that input, and chooses between two ways of counting:
- cycle counting adds one on every clock while the adjusted input is high;
- edge counting adds one on each rising edge of the adjusted input.

A global control word sets the following:
- a master enable;
- a freeze that stops every counter;
- saturation at all ones instead of wrapping;
- a privilege-mode filter that is compared against the `privMode` input;
- the split bit of each physical counter.

A counter that wraps, or that reaches all ones while saturation is on, latches an overflow flag. The OR of all flags drives `irq`. Reading the status word returns the flags and clears them in the same access.

Software reaches every word through a synchronous register port. A write takes effect at the clock edge. Read data appears on `regRdata` one cycle after `regRe` and is zero in cycles without a read.

Word addresses:
- global control at 0x00;
- status at 0x01;
- control word of logical counter n at 0x08+n;
- full 32-bit value of physical counter p at 0x10+p;
- 16-bit half belonging to logical counter n at 0x18+n.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset all counters, control words and overflow flags are zero, `irq` is low and a read of any word returns zero.
- R2: Global control readback keeps only bit 31 (master enable), bit 30 (saturate), bit 20 (freeze), bits 19:18 (mode) and bits 24:21 (split), with all other bits zero. A logical control word keeps bits 31:26 (event select), 25 (input control), 24 (invert), 23 (cycle count) and 22 (enable), with bits 21:0 reading zero. Read data appears the cycle after `regRe`.
- R3: A counter counts the event input chosen by its select field. With bit 24 set that input is inverted first. With bit 23 set it adds one on every clock while the adjusted input is high. With bit 23 clear it adds one per rising edge of the adjusted input.
- R4: A counter advances only when all of these hold: master enable is 1, freeze is 0, its enable bit is 1, and the mode field equals `privMode` or is 3. Otherwise its value holds.
- R5: In 32-bit mode with saturation off, logical counter p (p<4) steps from 0xFFFFFFFF to 0 and sets status bit 31-p.
- R6: With saturation on, a counter that steps onto all ones sets its flag and then holds all ones without raising further flags.
- R7: Global bit 24-p splits physical counter p. Logical counter p then uses bits 31:16 and logical counter p+4 uses bits 15:0. The two halves count, wrap and saturate independently with no carry between them, and a lower-half overflow sets status bit 31-(p+4).
- R8: A read of the status word (bit 31-n holds the flag of logical counter n) returns the flags and clears them. An overflow in the same cycle as the read stays set. `irq` is high while any flag is set.
- R9: A write to a counter value loads it at that edge, wins over an increment in the same cycle, and leaves overflow flags untouched.
- R10: In 32-bit mode the control words of logical counters 4 to 7 have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 5 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after regRe |
| events | input | 64 | Event inputs |
| privMode | input | 2 | Current privilege mode |
| irq | output | 1 | High while any overflow flag is set |

## Verification
The bench sweeps every one of the 64 event selects against all four physical counters while a neighbouring input toggles. An off-by-one in the event multiplexer would therefore count noise and return the wrong value.

The bench drives every pairing of the mode field with the privilege input. A filter that ignored the "all modes" value, or compared the wrong bits, would count when it should hold.

The wrap and saturate tests sit on the last steps before all ones:
- wrapping when saturation is on would show up as a zero value;
- flagging on every held increment would show up as a flag that returns after it has been cleared.

Split-mode tests place one half at its limit next to a live half. A design that carried between halves, or routed the lower-half flag to the wrong bit, would give a changed neighbour or a wrong status word.

A status read is timed to land in the very cycle of a wrap. A design that cleared unconditionally would lose that flag.

A counter write is placed in a cycle where the counter is incrementing. Letting the increment win would read back one too many.

// File: rtl/perfbank_pkg.sv
package perfbank_pkg;
  localparam int PB_PHYS   = 4;
  localparam int PB_LOG    = 2 * PB_PHYS;
  localparam int PB_W      = 32;
  localparam int PB_HALF   = PB_W / 2;
  localparam int PB_EVENTS = 64;
  localparam int PB_SEL_W  = $clog2(PB_EVENTS);
  localparam int PB_AW     = 5;
  localparam int PB_IDX_W  = $clog2(PB_LOG);
  localparam int PB_PIDX_W = $clog2(PB_PHYS);
  localparam int PB_GRP_W  = PB_AW - PB_IDX_W;
  localparam int PB_SPLIT_TOP = 24;

  localparam logic [PB_GRP_W-1:0] GRP_MISC = 2'd0;
  localparam logic [PB_GRP_W-1:0] GRP_CTL  = 2'd1;
  localparam logic [PB_GRP_W-1:0] GRP_PHYS = 2'd2;
  localparam logic [PB_GRP_W-1:0] GRP_HALF = 2'd3;
  localparam logic [PB_AW-1:0] ADDR_GLB = 5'h00;
  localparam logic [PB_AW-1:0] ADDR_STS = 5'h01;

  typedef struct packed {
    logic [PB_SEL_W-1:0] sel;
    logic                inCtl;
    logic                pol;
    logic                cyc;
    logic                en;
  } pbCtl_t;

  localparam int PB_CTL_LSB = PB_W - $bits(pbCtl_t);

  typedef struct packed {
    logic [PB_PHYS-1:0] physLoad;
    logic [PB_LOG-1:0]  halfLoad;
    logic [PB_W-1:0]    loadData;
    logic [PB_LOG-1:0]  countGo;
  } pbStrobe_t;
endpackage

// File: rtl/perfbank_ctrl.sv
module perfbank_ctrl
  import perfbank_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic                          regRe,
  input  logic [PB_AW-1:0]              regAddr,
  input  logic [PB_W-1:0]               regWdata,
  output logic [PB_W-1:0]               regRdata,
  input  logic [1:0]                    privMode,
  input  logic [PB_PHYS-1:0][PB_W-1:0]  physVal,
  input  logic [PB_LOG-1:0]             ovfPulse,
  output pbStrobe_t                     strobe,
  output pbCtl_t [PB_LOG-1:0]           ctlArr,
  output logic [PB_PHYS-1:0]            splitMask,
  output logic                          stopMaxQ,
  output logic                          masterQ,
  output logic                          freezeQ,
  output logic [PB_LOG-1:0]             flags,
  output logic                          irq
);
  logic [1:0]              modeQ;
  logic [PB_GRP_W-1:0]     grp;
  logic [PB_IDX_W-1:0]     idx;
  logic [PB_PIDX_W-1:0]    pIdx;
  logic                    stsRead;
  logic                    modeOk;
  logic [PB_W-1:0]         glbWord;
  logic [PB_W-1:0]         stsWord;
  logic [PB_W-1:0]         rdNext;

  assign grp     = regAddr[PB_AW-1:PB_IDX_W];
  assign idx     = regAddr[PB_IDX_W-1:0];
  assign pIdx    = idx[PB_PIDX_W-1:0];
  assign stsRead = regRe && (regAddr == ADDR_STS);
  assign modeOk  = (modeQ == 2'd3) || (modeQ == privMode);

  always_comb begin
    glbWord = '0;
    glbWord[31] = masterQ;
    glbWord[30] = stopMaxQ;
    glbWord[20] = freezeQ;
    glbWord[19:18] = modeQ;
    for (int p = 0; p < PB_PHYS; p++) glbWord[PB_SPLIT_TOP - p] = splitMask[p];
    stsWord = '0;
    for (int n = 0; n < PB_LOG; n++) stsWord[PB_W - 1 - n] = flags[n];
  end

  always_comb begin
    rdNext = '0;
    case (grp)
      GRP_MISC: begin
        if (regAddr == ADDR_GLB)      rdNext = glbWord;
        else if (regAddr == ADDR_STS) rdNext = stsWord;
      end
      GRP_CTL:  rdNext = {ctlArr[idx], {PB_CTL_LSB{1'b0}}};
      GRP_PHYS: if (int'(idx) < PB_PHYS) rdNext = physVal[pIdx];
      default: begin
        if (idx[PB_IDX_W-1]) rdNext = {{PB_HALF{1'b0}}, physVal[pIdx][PB_HALF-1:0]};
        else                 rdNext = {{PB_HALF{1'b0}}, physVal[pIdx][PB_W-1:PB_HALF]};
      end
    endcase
  end

  always_comb begin
    strobe.loadData = regWdata;
    for (int p = 0; p < PB_PHYS; p++)
      strobe.physLoad[p] = regWe && (grp == GRP_PHYS) && (int'(idx) == p);
    for (int n = 0; n < PB_LOG; n++) begin
      strobe.halfLoad[n] = regWe && (grp == GRP_HALF) && (int'(idx) == n);
      strobe.countGo[n]  = masterQ && !freezeQ && ctlArr[n].en && modeOk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterQ   <= 1'b0;
      stopMaxQ  <= 1'b0;
      freezeQ   <= 1'b0;
      modeQ     <= 2'd0;
      splitMask <= '0;
      ctlArr    <= '0;
      flags     <= '0;
      regRdata  <= '0;
    end else begin
      if (regWe && regAddr == ADDR_GLB) begin
        masterQ  <= regWdata[31];
        stopMaxQ <= regWdata[30];
        freezeQ  <= regWdata[20];
        modeQ    <= regWdata[19:18];
        for (int p = 0; p < PB_PHYS; p++) splitMask[p] <= regWdata[PB_SPLIT_TOP - p];
      end
      if (regWe && grp == GRP_CTL) ctlArr[idx] <= pbCtl_t'(regWdata[PB_W-1:PB_CTL_LSB]);
      flags    <= stsRead ? ovfPulse : (flags | ovfPulse);
      regRdata <= regRe ? rdNext : '0;
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/perfbank_datapath.sv
module perfbank_datapath
  import perfbank_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PB_EVENTS-1:0]          events,
  input  pbStrobe_t                     strobe,
  input  pbCtl_t [PB_LOG-1:0]           ctlArr,
  input  logic [PB_PHYS-1:0]            splitMask,
  input  logic                          stopMaxQ,
  output logic [PB_PHYS-1:0][PB_W-1:0]  physVal,
  output logic [PB_LOG-1:0]             ovfPulse
);
  logic [PB_LOG-1:0] lvl;
  logic [PB_LOG-1:0] prevQ;
  logic [PB_LOG-1:0] inc;

  function automatic logic [PB_HALF:0] stepHalf(input logic [PB_HALF-1:0] v, input logic sat);
    logic [PB_HALF-1:0] nv;
    if (&v) return sat ? {1'b0, v} : {1'b1, {PB_HALF{1'b0}}};
    nv = v + 1'b1;
    return {sat & (&nv), nv};
  endfunction

  function automatic logic [PB_W:0] stepFull(input logic [PB_W-1:0] v, input logic sat);
    logic [PB_W-1:0] nv;
    if (&v) return sat ? {1'b0, v} : {1'b1, {PB_W{1'b0}}};
    nv = v + 1'b1;
    return {sat & (&nv), nv};
  endfunction

  genvar n, p;
  generate
    for (n = 0; n < PB_LOG; n++) begin : g_log
      assign lvl[n] = events[ctlArr[n].sel] ^ ctlArr[n].pol;
      assign inc[n] = strobe.countGo[n] && (ctlArr[n].cyc ? lvl[n] : (lvl[n] && !prevQ[n]));
    end

    for (p = 0; p < PB_PHYS; p++) begin : g_phys
      localparam int LO = p + PB_PHYS;
      logic [PB_W-1:0] nxt;
      logic            ovfHi, ovfLo;
      logic [PB_W:0]   fullStep;
      logic [PB_HALF:0] hiStep, loStep;

      assign fullStep = stepFull(physVal[p], stopMaxQ);
      assign hiStep   = stepHalf(physVal[p][PB_W-1:PB_HALF], stopMaxQ);
      assign loStep   = stepHalf(physVal[p][PB_HALF-1:0], stopMaxQ);

      always_comb begin
        nxt   = physVal[p];
        ovfHi = 1'b0;
        ovfLo = 1'b0;
        if (strobe.physLoad[p]) begin
          nxt = strobe.loadData;
        end else if (!splitMask[p]) begin
          if (strobe.halfLoad[p])  nxt[PB_W-1:PB_HALF] = strobe.loadData[PB_HALF-1:0];
          if (strobe.halfLoad[LO]) nxt[PB_HALF-1:0]    = strobe.loadData[PB_HALF-1:0];
          if (!strobe.halfLoad[p] && !strobe.halfLoad[LO] && inc[p]) begin
            nxt   = fullStep[PB_W-1:0];
            ovfHi = fullStep[PB_W];
          end
        end else begin
          if (strobe.halfLoad[p]) nxt[PB_W-1:PB_HALF] = strobe.loadData[PB_HALF-1:0];
          else if (inc[p]) begin
            nxt[PB_W-1:PB_HALF] = hiStep[PB_HALF-1:0];
            ovfHi = hiStep[PB_HALF];
          end
          if (strobe.halfLoad[LO]) nxt[PB_HALF-1:0] = strobe.loadData[PB_HALF-1:0];
          else if (inc[LO]) begin
            nxt[PB_HALF-1:0] = loStep[PB_HALF-1:0];
            ovfLo = loStep[PB_HALF];
          end
        end
      end

      assign ovfPulse[p]  = ovfHi;
      assign ovfPulse[LO] = ovfLo;

      always_ff @(posedge clk) begin
        if (!rstN) physVal[p] <= '0;
        else       physVal[p] <= nxt;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= lvl;
  end
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perfbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic                  regRe,
  input  logic [PB_AW-1:0]      regAddr,
  input  logic [PB_W-1:0]       regWdata,
  output logic [PB_W-1:0]       regRdata,
  input  logic [PB_EVENTS-1:0]  events,
  input  logic [1:0]            privMode,
  output logic                  irq
);
  pbStrobe_t                     strobe;
  pbCtl_t [PB_LOG-1:0]           ctlArr;
  logic [PB_PHYS-1:0]            splitMask;
  logic                          stopMaxQ;
  logic                          masterQ;
  logic                          freezeQ;
  logic [PB_LOG-1:0]             flags;
  logic [PB_LOG-1:0]             ovfPulse;
  logic [PB_PHYS-1:0][PB_W-1:0]  physVal;

  perfbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .privMode(privMode),
    .physVal(physVal), .ovfPulse(ovfPulse), .strobe(strobe), .ctlArr(ctlArr),
    .splitMask(splitMask), .stopMaxQ(stopMaxQ), .masterQ(masterQ),
    .freezeQ(freezeQ), .flags(flags), .irq(irq)
  );

  perfbank_datapath u_dp (
    .clk(clk), .rstN(rstN), .events(events), .strobe(strobe), .ctlArr(ctlArr),
    .splitMask(splitMask), .stopMaxQ(stopMaxQ), .physVal(physVal),
    .ovfPulse(ovfPulse)
  );
endmodule

// File: rtl/perfbank_chk.sv
module perfbank_chk
  import perfbank_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWe,
  input logic                          regRe,
  input logic [PB_AW-1:0]              regAddr,
  input logic                          masterQ,
  input logic                          freezeQ,
  input logic [PB_PHYS-1:0][PB_W-1:0]  physVal,
  input logic [PB_LOG-1:0]             flags,
  input logic [PB_LOG-1:0]             ovfPulse,
  input logic                          irq
);
  logic stsRd;
  assign stsRd = regRe && (regAddr == ADDR_STS);

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (freezeQ && !regWe) |=> $stable(physVal)); // R4
  AST_MASTER_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!masterQ && !regWe) |=> $stable(physVal)); // R4
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stsRd |=> ((flags & $past(flags)) == $past(flags))); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stsRd |=> (flags == $past(ovfPulse))); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(ovfPulse) != '0)); // R8
endmodule

bind perf_ctr_bank perfbank_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
  .masterQ(masterQ), .freezeQ(freezeQ), .physVal(physVal), .flags(flags),
  .ovfPulse(ovfPulse), .irq(irq)
);

// File: tb/perf_ctr_bank_tb.sv
module perf_ctr_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] events = '0;
  logic [1:0]  privMode = 2'd0;
  logic        irq;
  int checks = 0;
  int fails = 0;
  logic [31:0] rv;

  localparam logic [31:0] MASTER = 32'h8000_0000;
  localparam logic [31:0] SAT    = 32'h4000_0000;
  localparam logic [31:0] FRZ    = 32'h0010_0000;
  localparam logic [31:0] ALLM   = 32'h000C_0000;
  localparam logic [31:0] CYC    = 32'h0080_0000;
  localparam logic [31:0] EN     = 32'h0040_0000;
  localparam logic [31:0] POL    = 32'h0100_0000;

  perf_ctr_bank u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .events(events),
    .privMode(privMode), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); regRe = 1'b1; regAddr = a;
    @(negedge clk); regRe = 1'b0; d = regRdata;
  endtask

  task automatic hold(input int idx, input int k, input logic act);
    @(negedge clk); events[idx] = act;
    repeat (k) @(negedge clk);
    events[idx] = ~act;
  endtask

  task automatic pulses(input int idx, input int k, input logic act);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); events[idx] = act;
      @(negedge clk); events[idx] = ~act;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(5'h00, rv); chk("R1 global", rv, 0);
    rd(5'h01, rv); chk("R1 status", rv, 0);
    for (int p = 0; p < 4; p++) begin rd(5'h10 + 5'(p), rv); chk("R1 counter", rv, 0); end
    // R2 readback masks
    wr(5'h0B, 32'hFFFF_FFFF); rd(5'h0B, rv); chk("R2 ctl word", rv, 32'hFFC0_0000);
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, rv); chk("R2 global word", rv, 32'hC1FC_0000);
    wr(5'h00, 0); wr(5'h0B, 0);
    // R3 select sweep, cycle mode, neighbour toggling
    wr(5'h00, MASTER | ALLM);
    for (int s = 0; s < 64; s++) begin
      int n = s % 4;
      int k = (s % 7) + 1;
      wr(5'h08 + 5'(n), (32'(s) << 26) | CYC | EN);
      wr(5'h10 + 5'(n), 0);
      events[(s + 1) % 64] = 1'b1;
      hold(s, k, 1'b1);
      events[(s + 1) % 64] = 1'b0;
      rd(5'h10 + 5'(n), rv); chk("R3 select sweep", rv, 32'(k));
    end
    // R3 edge mode
    wr(5'h09, (32'd20 << 26) | EN); wr(5'h11, 0);
    pulses(20, 5, 1'b1); rd(5'h11, rv); chk("R3 edge count", rv, 5);
    wr(5'h11, 0); hold(20, 10, 1'b1); rd(5'h11, rv); chk("R3 long level one edge", rv, 1);
    // R3 polarity, edge and cycle
    events[21] = 1'b1;
    wr(5'h09, (32'd21 << 26) | POL | EN); wr(5'h11, 0);
    pulses(21, 4, 1'b0); rd(5'h11, rv); chk("R3 inverted edge", rv, 4);
    events[22] = 1'b1;
    wr(5'h09, (32'd22 << 26) | POL | CYC | EN); wr(5'h11, 0);
    hold(22, 6, 1'b0); rd(5'h11, rv); chk("R3 inverted level", rv, 6);
    events[21] = 1'b0; events[22] = 1'b0;
    // R4 gating
    wr(5'h08, (32'd2 << 26) | CYC | EN);
    wr(5'h00, ALLM); wr(5'h10, 0); hold(2, 4, 1'b1);
    rd(5'h10, rv); chk("R4 master off", rv, 0);
    wr(5'h00, MASTER | ALLM | FRZ); hold(2, 4, 1'b1);
    rd(5'h10, rv); chk("R4 freeze", rv, 0);
    wr(5'h00, MASTER | ALLM); wr(5'h08, (32'd2 << 26) | CYC); hold(2, 4, 1'b1);
    rd(5'h10, rv); chk("R4 counter disabled", rv, 0);
    wr(5'h08, (32'd2 << 26) | CYC | EN);
    for (int m = 0; m < 4; m++) begin
      for (int pm = 0; pm < 4; pm++) begin
        privMode = 2'(pm);
        wr(5'h00, MASTER | (32'(m) << 18)); wr(5'h10, 0);
        hold(2, 3, 1'b1);
        rd(5'h10, rv);
        chk("R4 privilege filter", rv, (m == 3 || m == pm) ? 32'd3 : 32'd0);
      end
    end
    privMode = 2'd0;
    // R10 upper logical controls inert when unsplit
    wr(5'h00, MASTER | ALLM); wr(5'h09, 0); wr(5'h0D, (32'd9 << 26) | CYC | EN);
    wr(5'h11, 32'h1234); hold(9, 5, 1'b1);
    rd(5'h11, rv); chk("R10 counter 5 inert", rv, 32'h1234);
    wr(5'h0D, 0);
    // R5 wrap
    rd(5'h01, rv);
    wr(5'h09, (32'd3 << 26) | CYC | EN); wr(5'h11, 32'hFFFF_FFFE);
    hold(3, 3, 1'b1); rd(5'h11, rv); chk("R5 wrap value", rv, 1);
    chk("R8 irq set", {31'b0, irq}, 1);
    rd(5'h01, rv); chk("R5 flag bit 30", rv, 32'h4000_0000);
    rd(5'h01, rv); chk("R8 cleared by read", rv, 0);
    chk("R8 irq clear", {31'b0, irq}, 0);
    // R6 saturate
    wr(5'h00, MASTER | ALLM | SAT);
    wr(5'h0A, (32'd4 << 26) | CYC | EN); wr(5'h12, 32'hFFFF_FFFD);
    hold(4, 5, 1'b1); rd(5'h12, rv); chk("R6 held at max", rv, 32'hFFFF_FFFF);
    rd(5'h01, rv); chk("R6 flag bit 29", rv, 32'h2000_0000);
    hold(4, 3, 1'b1); rd(5'h01, rv); chk("R6 no repeat flag", rv, 0);
    rd(5'h12, rv); chk("R6 still max", rv, 32'hFFFF_FFFF);
    wr(5'h0A, 0);
    // R7 split
    wr(5'h00, MASTER | ALLM | 32'h0100_0000);
    wr(5'h08, (32'd10 << 26) | CYC | EN); wr(5'h0C, (32'd11 << 26) | CYC | EN);
    wr(5'h18, 32'hFFFE); wr(5'h1C, 32'h0010);
    hold(10, 3, 1'b1); hold(11, 2, 1'b1);
    rd(5'h18, rv); chk("R7 upper half wrap", rv, 1);
    rd(5'h1C, rv); chk("R7 lower half", rv, 32'h12);
    rd(5'h10, rv); chk("R7 physical view", rv, 32'h0001_0012);
    rd(5'h01, rv); chk("R7 upper flag", rv, 32'h8000_0000);
    wr(5'h1C, 32'hFFFF); hold(11, 1, 1'b1);
    rd(5'h10, rv); chk("R7 no carry", rv, 32'h0001_0000);
    rd(5'h01, rv); chk("R7 lower flag bit 27", rv, 32'h0800_0000);
    wr(5'h00, MASTER | ALLM | SAT | 32'h0080_0000);
    wr(5'h0D, (32'd12 << 26) | CYC | EN); wr(5'h1D, 32'hFFFE);
    hold(12, 3, 1'b1); rd(5'h1D, rv); chk("R7 lower half saturates", rv, 32'hFFFF);
    rd(5'h01, rv); chk("R7 flag bit 26", rv, 32'h0400_0000);
    wr(5'h0C, 0); wr(5'h0D, 0);
    // R8 same-cycle overflow survives read
    wr(5'h00, MASTER | ALLM);
    wr(5'h0B, (32'd3 << 26) | CYC | EN); wr(5'h13, 32'hFFFF_FFFF);
    @(negedge clk); events[3] = 1'b1; regRe = 1'b1; regAddr = 5'h01;
    @(negedge clk); events[3] = 1'b0; regRe = 1'b0;
    chk("R8 read shows old flags", regRdata, 0);
    rd(5'h01, rv); chk("R8 same-cycle flag kept", rv, 32'h1000_0000);
    // R9 write beats increment, flag kept
    wr(5'h08, (32'd7 << 26) | CYC | EN); wr(5'h10, 32'hFFFF_FFFF);
    hold(7, 1, 1'b1);
    @(negedge clk); events[7] = 1'b1; regWe = 1'b1; regAddr = 5'h10; regWdata = 32'd100;
    @(negedge clk); regWe = 1'b0; regRe = 1'b1; regAddr = 5'h10;
    @(negedge clk); regRe = 1'b0; events[7] = 1'b0;
    chk("R9 load wins", regRdata, 100);
    rd(5'h01, rv); chk("R9 flag survives write", rv, 32'h8000_0000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule